// File: doc/BRIEF.md
# Dual Auxiliary Pulse-Width Modulator

This block drives two pulse-width modulated outputs from four byte-wide settings: a period and an on-time for each output. All timing is counted in units of two system clocks, produced by one strobe that both channels share. Software loads a setting through a write strobe, a two-bit selector and a data byte. A level input selects how the second output relates to the first.

With the mode input high, the two outputs are independent: each runs at its own period with its own duty. With the mode input low, both outputs share the first period setting, and the second period setting becomes a phase delay from the rise of the first output to the rise of the second. On-time changes are buffered until the channel's next cycle begins. Any period write, or any change of the mode input, restarts both timers at once. It can serve as a switching source for auxiliary converters or, after external filtering, as a coarse digital-to-analogue output.

Top module: `aux_pwm_pair`

## Requirements
- R1: While reset is asserted both outputs are low, and after reset all four settings read as zero, so both outputs stay low until software writes an on-time.
- R2: A channel's cycle lasts 2×(P+1) clocks, where P is its period setting (0 to 255), and the cycle repeats without gaps.
- R3: An output goes high at the first clock of its cycle, stays high for 2×C clocks where C is its on-time setting, then stays low for the rest of the cycle; C = 0 keeps the output low for the whole cycle.
- R4: When C is larger than P, the output is high for the entire cycle.
- R5: With mode_indep = 1 the second output uses the second period setting (selector 1) and runs unrelated to the first output.
- R6: With mode_indep = 0 the second output uses the first period setting (selector 0); after a restart it stays low for 2×(Q+1) clocks, where Q is the second period setting, and each of its cycles starts 2×(Q+1) clocks after a cycle start of the first output.
- R7: With mode_indep = 0 and Q not smaller than P, the delay is taken as 2×(P+1) clocks, so the second output's cycles start together with the first output's, after a first full period of low output.
- R8: A write of an on-time (selector 2 for the first output, 3 for the second) does not alter the current cycle; the new value governs from the channel's next cycle start.
- R9: A write to either period setting (selector 0 or 1), or a change of mode_indep, restarts both channels: the clock after the write edge is the first clock of a fresh cycle on the first output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, one setting per clock |
| wr_sel | input | 2 | Setting select: 0 first period, 1 second period, 2 first on-time, 3 second on-time |
| wr_data | input | DW | Value to write |
| mode_indep | input | 1 | 1: independent channels, 0: shared period with phase delay |
| aux0_o | output | 1 | First PWM output |
| aux1_o | output | 1 | Second PWM output |

## Verification
A wrong counter or strobe phase shows as an output edge displaced by one or two clocks within the first cycle after a restart, so each scenario compares every clock from the restart edge onward against a waveform computed from the settings. A stale or early-loaded on-time shows as a wrong high width in exactly one cycle, which the buffered-update scenario places mid-cycle to catch. A wrong offset delay or clamp shows as a misplaced first rise of the second output, visible within one period of the first output.

// File: rtl/aux_pwm_pkg.sv
package aux_pwm_pkg;

    // Write selector codes for the four settings.
    typedef enum logic [1:0] {
        SEL_PER0 = 2'd0,
        SEL_PER1 = 2'd1,
        SEL_ON0  = 2'd2,
        SEL_ON1  = 2'd3
    } aux_sel_e;

endpackage

// File: rtl/aux_pwm_regs.sv
module aux_pwm_regs
    import aux_pwm_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          mode_in,
    output logic [DW-1:0] per0_o,
    output logic [DW-1:0] per1_o,
    output logic [DW-1:0] on0_o,
    output logic [DW-1:0] on1_o,
    output logic          mode_o,
    output logic          restart_o
);

    typedef struct packed {
        logic [DW-1:0] per0;
        logic [DW-1:0] per1;
        logic [DW-1:0] on0;
        logic [DW-1:0] on1;
        logic          mode;
        logic          started;
    } regs_t;

    regs_t st_d, st_q;
    logic  restart_c;

    always_comb begin
        st_d      = st_q;
        // A period write, a mode change or the first clock out of reset
        // begins fresh cycles on both channels.
        restart_c = !st_q.started || (mode_in != st_q.mode) ||
                    (wr_en && ((wr_sel == SEL_PER0) || (wr_sel == SEL_PER1)));
        st_d.started = 1'b1;
        st_d.mode    = mode_in;
        if (wr_en) begin
            unique case (wr_sel)
                SEL_PER0: st_d.per0 = wr_data;
                SEL_PER1: st_d.per1 = wr_data;
                SEL_ON0:  st_d.on0  = wr_data;
                default:  st_d.on1  = wr_data;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign per0_o    = st_q.per0;
    assign per1_o    = st_q.per1;
    assign on0_o     = st_q.on0;
    assign on1_o     = st_q.on1;
    assign mode_o    = st_q.mode;
    assign restart_o = restart_c;

endmodule

// File: rtl/aux_pwm_tick.sv
module aux_pwm_tick (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    output logic tick
);

    typedef struct packed {
        logic phase;
    } tick_t;

    tick_t tk_d, tk_q;

    always_comb begin
        tk_d = tk_q;
        if (clear) tk_d.phase = 1'b0;
        else       tk_d.phase = ~tk_q.phase;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tk_q <= '0;
        else        tk_q <= tk_d;
    end

    // One strobe every second clock; the clock after a clear has none.
    assign tick = tk_q.phase;

endmodule

// File: rtl/aux_pwm_chan.sv
module aux_pwm_chan #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          restart,
    input  logic          restart_load,
    input  logic          sync,
    input  logic          wrap_load,
    input  logic [DW-1:0] per,
    input  logic [DW-1:0] on,
    output logic [DW-1:0] cnt_o,
    output logic [DW-1:0] act_o,
    output logic          pwm_o
);

    typedef struct packed {
        logic [DW-1:0] cnt;
        logic [DW-1:0] act;
    } chan_t;

    chan_t ch_d, ch_q;

    always_comb begin
        ch_d = ch_q;
        if (restart) begin
            ch_d.cnt = '0;
            ch_d.act = restart_load ? on : '0;
        end else if (tick) begin
            if (sync) begin
                ch_d.cnt = '0;
                ch_d.act = on;
            end else if (ch_q.cnt == per) begin
                ch_d.cnt = '0;
                if (wrap_load) ch_d.act = on;
            end else begin
                ch_d.cnt = ch_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ch_q <= '0;
        else        ch_q <= ch_d;
    end

    assign cnt_o = ch_q.cnt;
    assign act_o = ch_q.act;
    assign pwm_o = (ch_q.cnt < ch_q.act);

endmodule

// File: rtl/aux_pwm_pair.sv
module aux_pwm_pair #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [DW-1:0] wr_data,
    input  logic          mode_indep,
    output logic          aux0_o,
    output logic          aux1_o
);

    localparam int NCH = 2;

    logic [DW-1:0] per0_q, per1_q, on0_q, on1_q;
    logic          mode_q;
    logic          restart_w;
    logic          tick_w;
    logic [DW-1:0] dly_w;

    logic [DW-1:0] ch_per  [NCH];
    logic [DW-1:0] ch_on   [NCH];
    logic          ch_sync [NCH];
    logic          ch_rld  [NCH];
    logic          ch_wld  [NCH];
    logic [DW-1:0] ch_cnt  [NCH];
    logic [DW-1:0] ch_act  [NCH];
    logic          ch_pwm  [NCH];

    aux_pwm_regs #(.DW(DW)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .mode_in   (mode_indep),
        .per0_o    (per0_q),
        .per1_o    (per1_q),
        .on0_o     (on0_q),
        .on1_o     (on1_q),
        .mode_o    (mode_q),
        .restart_o (restart_w)
    );

    aux_pwm_tick u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (restart_w),
        .tick  (tick_w)
    );

    // Offset delay, clamped to the shared period.
    assign dly_w = (per1_q < per0_q) ? per1_q : per0_q;

    always_comb begin
        ch_per[0]  = per0_q;
        ch_on[0]   = on0_q;
        ch_sync[0] = 1'b0;
        ch_rld[0]  = 1'b1;
        ch_wld[0]  = 1'b1;
        ch_per[1]  = mode_indep ? per1_q : per0_q;
        ch_on[1]   = on1_q;
        ch_sync[1] = !mode_indep && (ch_cnt[0] == dly_w);
        ch_rld[1]  = mode_indep;
        ch_wld[1]  = mode_indep;
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        aux_pwm_chan #(.DW(DW)) u_chan (
            .clk          (clk),
            .rst_n        (rst_n),
            .tick         (tick_w),
            .restart      (restart_w),
            .restart_load (ch_rld[g]),
            .sync         (ch_sync[g]),
            .wrap_load    (ch_wld[g]),
            .per          (ch_per[g]),
            .on           (ch_on[g]),
            .cnt_o        (ch_cnt[g]),
            .act_o        (ch_act[g]),
            .pwm_o        (ch_pwm[g])
        );
    end

    assign aux0_o = ch_pwm[0];
    assign aux1_o = ch_pwm[1];

endmodule

// File: rtl/aux_pwm_pair_chk.sv
module aux_pwm_pair_chk #(
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [1:0]    wr_sel,
    input logic          aux0,
    input logic          aux1,
    input logic          mode_q,
    input logic          restart,
    input logic          tick,
    input logic [DW-1:0] cnt0,
    input logic [DW-1:0] cnt1,
    input logic [DW-1:0] act0,
    input logic [DW-1:0] per0,
    input logic [DW-1:0] per1
);

    logic [DW-1:0] dly_c;
    logic [DW-1:0] rise_cnt_c;

    always_comb begin
        dly_c      = (per1 < per0) ? per1 : per0;
        rise_cnt_c = (dly_c == per0) ? '0 : dly_c + 1'b1;
    end

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!aux0 && !aux1));

    // R2
    cnt0_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt0 <= per0);

    // R3
    rise_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(aux0) |-> (cnt0 == '0));

    // R5
    cnt1_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_q |-> (cnt1 <= per1));

    // R6
    offset_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_q && $rose(aux1)) |-> (cnt0 == rise_cnt_c));

    // R8
    on_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!restart && !(tick && (cnt0 == per0))) |=> $stable(act0));

    // R9
    period_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel[1] == 1'b0)) |=> ((cnt0 == '0) && (cnt1 == '0)));

endmodule

bind aux_pwm_pair aux_pwm_pair_chk #(.DW(DW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_sel  (wr_sel),
    .aux0    (aux0_o),
    .aux1    (aux1_o),
    .mode_q  (mode_q),
    .restart (restart_w),
    .tick    (tick_w),
    .cnt0    (ch_cnt[0]),
    .cnt1    (ch_cnt[1]),
    .act0    (ch_act[0]),
    .per0    (per0_q),
    .per1    (per1_q)
);

// File: tb/aux_pwm_pair_test.sv
module aux_pwm_pair_test;

    localparam int CLK_P = 10;
    localparam int DW    = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_sel = '0;
    logic [DW-1:0] wr_data = '0;
    logic          mode_indep = 1'b1;
    logic          aux0_o, aux1_o;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic  e0;
        logic  e1;
        string tag;
    } exp_t;

    exp_t exp_q[$];

    aux_pwm_pair #(.DW(DW)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .mode_indep (mode_indep),
        .aux0_o     (aux0_o),
        .aux1_o     (aux1_o)
    );

    always #(CLK_P/2) clk = ~clk;

    // Expected level at clock k after a restart, from the requirements.
    function automatic logic model(int k, int p, int start, int on_a, int on_b, int kw);
        int t, pos, ks, on;
        if (k < start) return 1'b0;
        t   = (k - start) / 2;
        pos = t % (p + 1);
        ks  = start + 2 * (t - pos);
        on  = (kw >= 0 && ks > kw) ? on_b : on_a;
        return (pos < on);
    endfunction

    // Monitor: pops one expected pair per clock, away from the edge.
    initial begin
        forever begin
            @(posedge clk);
            #(CLK_P/4);
            if (exp_q.size() > 0) begin
                exp_t it;
                it = exp_q.pop_front();
                n_cmp += 2;
                if (aux0_o !== it.e0) begin
                    n_bad++;
                    $display("FAIL %s aux0 actual=%b expected=%b t=%0t", it.tag, aux0_o, it.e0, $time);
                end
                if (aux1_o !== it.e1) begin
                    n_bad++;
                    $display("FAIL %s aux1 actual=%b expected=%b t=%0t", it.tag, aux1_o, it.e1, $time);
                end
            end
        end
    end

    task automatic put(logic e0, logic e1, string tag);
        exp_t it;
        it.e0 = e0; it.e1 = e1; it.tag = tag;
        exp_q.push_back(it);
    endtask

    task automatic wr(logic [1:0] sel, int val);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = DW'(val);
    endtask

    // Driver: programs the settings, triggers a restart and pushes the
    // expected waveform; optionally rewrites the first on-time mid-run.
    task automatic run_case(string tag, bit indep, int p0, int p1, int c0, int c1,
                            int n, bit by_mode, int chg_at, int chg_val);
        int kw, d;
        kw = (chg_at >= 0) ? chg_at + 2 : -1;
        d  = ((p1 < p0) ? p1 : p0) + 1;
        if (!by_mode) begin
            @(negedge clk);
            wr_en = 1'b0; mode_indep = indep;
        end
        wr(2'd2, c0);
        wr(2'd3, c1);
        wr(2'd1, p1);
        if (by_mode) wr(2'd0, p0);
        @(negedge clk);
        if (by_mode) begin
            wr_en = 1'b0; mode_indep = indep;
        end else begin
            wr_en = 1'b1; wr_sel = 2'd0; wr_data = DW'(p0);
        end
        for (int k = 0; k < n; k++) begin
            logic e0, e1;
            e0 = model(k, p0, 0, c0, chg_val, kw);
            if (indep) e1 = model(k, p1, 0, c1, c1, -1);
            else       e1 = model(k, p0, 2 * d, c1, c1, -1);
            put(e0, e1, tag);
        end
        @(negedge clk);
        wr_en = 1'b0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (i == chg_at) begin
                wr_en = 1'b1; wr_sel = 2'd2; wr_data = DW'(chg_val);
            end else if (i == chg_at + 1) begin
                wr_en = 1'b0;
            end
        end
    endtask

    initial begin
        // R1: outputs low during reset and with cleared settings after it
        for (int i = 0; i < 5; i++) put(1'b0, 1'b0, "R1 in reset");
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 6; i++) put(1'b0, 1'b0, "R1 after reset");
        repeat (8) @(negedge clk);

        run_case("R2 R3 R5",   1'b1, 4,   2,   2,   1,   40,   1'b0, -1, 0);
        run_case("R3 R4 R9",   1'b1, 5,   3,   0,   5,   30,   1'b0, -1, 0);
        run_case("R6",         1'b0, 5,   2,   3,   2,   50,   1'b0, -1, 0);
        run_case("R7 above",   1'b0, 3,   7,   2,   1,   40,   1'b0, -1, 0);
        run_case("R7 equal",   1'b0, 4,   4,   1,   3,   40,   1'b0, -1, 0);
        run_case("R8",         1'b1, 6,   3,   2,   2,   50,   1'b0,  4, 5);
        run_case("R9 R6 mode", 1'b0, 4,   1,   2,   3,   30,   1'b1, -1, 0);
        run_case("R2 R4 R5",   1'b1, 255, 0,   255, 200, 1100, 1'b0, -1, 0);

        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule